// File: doc/BRIEF.md
# Continuous-Scan ADC Channel Sequencer

This block sequences a multi-channel successive-approximation converter that scans without stopping. A run bit can be set by a software pulse, by a trigger that is already in the clock domain, or by a trigger from another clock domain. Once the run bit is set, the block opens a joint sample-and-hold window. In that window, every low channel that has been flagged to use its own hold stage captures its input at the same moment. The block then steps through the enabled channels one at a time, lowest number first. Each result goes into that channel's own result register.

When the last enabled channel of a scan returns its result, the block can raise a one-cycle scan-end interrupt. In the same cycle it reopens the joint sampling window, so the scan repeats for as long as the run bit stays set. Hardware never clears the run bit; only a software clear pulse does. A clear sends the sequencer to idle. A conversion still in flight at that point loses its result. A channel without a dedicated hold stage is sampled through the shared converter path during its own conversion slot, and the block tells the converter which case applies.

The converter sits outside the block. The handshake is a one-cycle start pulse with a channel number, followed some cycles later by a one-cycle done pulse carrying a 12-bit result.

Top module: `adc_scan_seq`

## Requirements
- R1: `run` goes to 1 in the cycle after a `sw_set` pulse or a `sync_trig` pulse, and in the cycle after the rising edge of `async_trig` has passed a two-flop synchronizer and edge detector. `run` holds its value until a `sw_clr` pulse, which takes priority over any set in the same cycle.
- R2: When `run` is 1, the block is idle and `ch_en` is nonzero, the block enters a sampling window. The window lasts `sh_cycles` cycles, or 1 cycle when `sh_cycles` is 0. During the window `sh_phase` is 1 and `sh_sample` equals `sh_sel`. At all other times `sh_sample` is 0.
- R3: After the window, the block converts each channel whose `ch_en` bit is 1, in ascending order. For each channel it drives a one-cycle `cnv_start` with `cnv_ch` equal to the channel number, then waits for `cnv_done`.
- R4: Throughout a channel's slot, `cnv_use_sh` is 1 exactly when the channel number is below 3 and its bit in `sh_sel` is 1. Bit i of `sh_sel` belongs to channel i.
- R5: On `cnv_done`, the block stores `cnv_data` into the result register of the channel being converted. The new value is visible in `res_all[ch*12 +: 12]` in the next cycle. All other result registers keep their values.
- R6: When the last enabled channel completes, `scan_irq` pulses for one cycle if `irq_en` is 1. In that same cycle the next sampling window begins.
- R7: The scan repeats, producing one scan end per pass, for as long as `run` stays 1.
- R8: Once `run` is 0, the block returns to idle within one cycle and issues no further `cnv_start`. A `cnv_done` that arrives after the stop leaves every result register unchanged.
- R9: Setting `run` again from idle always begins with a sampling window before any `cnv_start`.
- R10: While `ch_en` is 0, no `cnv_start` and no `scan_irq` occur, even if `run` is 1.
- R11: After reset, `run`, `sh_phase`, `sh_sample`, `cnv_start` and `scan_irq` are 0, and all result registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_set | input | 1 | Software pulse that sets the run bit |
| sw_clr | input | 1 | Software pulse that clears the run bit |
| sync_trig | input | 1 | In-domain trigger pulse that sets the run bit |
| async_trig | input | 1 | Trigger from another clock domain; its rising edge sets the run bit |
| ch_en | input | 8 | Channel enable mask, bit i for channel i |
| sh_sel | input | 3 | Dedicated sample-and-hold select for channels 0 to 2 |
| sh_cycles | input | 8 | Length of the sampling window in cycles (0 is treated as 1) |
| irq_en | input | 1 | Scan-end interrupt enable |
| run | output | 1 | Current run bit |
| sh_phase | output | 1 | High during the joint sampling window |
| sh_sample | output | 3 | Sample command to the dedicated hold stages |
| cnv_start | output | 1 | One-cycle conversion start |
| cnv_ch | output | 3 | Channel of the current conversion slot |
| cnv_use_sh | output | 1 | Current channel takes its value from its dedicated hold stage |
| cnv_done | input | 1 | One-cycle conversion complete |
| cnv_data | input | 12 | Conversion result, valid with `cnv_done` |
| scan_irq | output | 1 | One-cycle scan-end interrupt |
| res_all | output | 96 | Result registers, channel i in bits i*12 +: 12 |

## Verification
The assertions assume three things about the environment. The converter answers each `cnv_start` with exactly one `cnv_done`. `irq_en`, `ch_en`, `sh_sel` and `sh_cycles` change only while the sequencer is idle. A new run is not started while a conversion cut short by a stop is still outstanding. The stimulus meets all three: its converter model has a fixed latency of six cycles, configuration is rewritten only after a clear followed by twenty idle cycles, and each stop is followed by that same wait before the next start.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_ISSUE = 2'd2,
        PH_WAIT  = 2'd3
    } phase_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    // edge seen once the synchronized level rises
    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/adc_ch_pick.sv
module adc_ch_pick #(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic           from_start,
    input  logic [CHW-1:0] after,
    output logic           found,
    output logic [CHW-1:0] idx
);
    // lowest enabled channel, either overall or strictly above 'after'
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (from_start || i > int'(after))) begin
                found = 1'b1;
                idx   = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NCH = 8,
    parameter int DW  = 12,
    parameter int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CHW-1:0]    waddr,
    input  logic [DW-1:0]     wdata,
    output logic [NCH*DW-1:0] rd_all
);
    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic [DW-1:0] val_d, val_q;
        always_comb begin
            val_d = val_q;
            if (we && waddr == CHW'(g)) val_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end
        assign rd_all[g*DW +: DW] = val_q;
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int NSH = 3,
    parameter int DW  = 12,
    parameter int CW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_set,
    input  logic              sw_clr,
    input  logic              sync_trig,
    input  logic              async_trig,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NSH-1:0]    sh_sel,
    input  logic [CW-1:0]     sh_cycles,
    input  logic              irq_en,
    output logic              run,
    output logic              sh_phase,
    output logic [NSH-1:0]    sh_sample,
    output logic              cnv_start,
    output logic [$clog2(NCH)-1:0] cnv_ch,
    output logic              cnv_use_sh,
    input  logic              cnv_done,
    input  logic [DW-1:0]     cnv_data,
    output logic              scan_irq,
    output logic [NCH*DW-1:0] res_all
);
    localparam int CHW = $clog2(NCH);

    typedef struct packed {
        phase_e         ph;
        logic           run;
        logic [CW-1:0]  cnt;
        logic [CHW-1:0] ch;
        logic           irq;
    } seq_t;

    seq_t s_d, s_q;

    logic           async_rise;
    logic           pick_ok;
    logic [CHW-1:0] pick_idx;
    logic           wr_en;
    logic [CW-1:0]  hold_last;
    logic           slot_sh;

    adc_trig_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (async_trig),
        .rise     (async_rise)
    );

    adc_ch_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .mask       (ch_en),
        .from_start (s_q.ph == PH_HOLD),
        .after      (s_q.ch),
        .found      (pick_ok),
        .idx        (pick_idx)
    );

    adc_result_bank #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .waddr  (s_q.ch),
        .wdata  (cnv_data),
        .rd_all (res_all)
    );

    assign hold_last = (sh_cycles == '0) ? '0 : sh_cycles - 1'b1;

    always_comb begin
        slot_sh = 1'b0;
        for (int i = 0; i < NSH; i++) begin
            if (s_q.ch == CHW'(i)) slot_sh = sh_sel[i];
        end
    end

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        wr_en   = 1'b0;

        if (sw_clr)                               s_d.run = 1'b0;
        else if (sw_set || sync_trig || async_rise) s_d.run = 1'b1;

        if (s_q.ph != PH_IDLE && !s_q.run) begin
            s_d.ph = PH_IDLE;
        end else begin
            case (s_q.ph)
                PH_IDLE: begin
                    if (s_q.run && ch_en != '0) begin
                        s_d.ph  = PH_HOLD;
                        s_d.cnt = '0;
                    end
                end
                PH_HOLD: begin
                    if (s_q.cnt >= hold_last) begin
                        if (pick_ok) begin
                            s_d.ph = PH_ISSUE;
                            s_d.ch = pick_idx;
                        end else begin
                            s_d.ph = PH_IDLE;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_ISSUE: s_d.ph = PH_WAIT;
                PH_WAIT: begin
                    if (cnv_done) begin
                        wr_en = 1'b1;
                        if (pick_ok) begin
                            s_d.ph = PH_ISSUE;
                            s_d.ch = pick_idx;
                        end else begin
                            s_d.ph  = PH_HOLD;
                            s_d.cnt = '0;
                            s_d.irq = irq_en;
                        end
                    end
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= PH_IDLE;
            s_q.run <= 1'b0;
            s_q.cnt <= '0;
            s_q.ch  <= '0;
            s_q.irq <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run        = s_q.run;
    assign sh_phase   = (s_q.ph == PH_HOLD);
    assign sh_sample  = sh_phase ? sh_sel : '0;
    assign cnv_start  = (s_q.ph == PH_ISSUE);
    assign cnv_ch     = s_q.ch;
    assign cnv_use_sh = (s_q.ph == PH_ISSUE || s_q.ph == PH_WAIT) && slot_sh;
    assign scan_irq   = s_q.irq;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int NCH = 8,
    parameter int NSH = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run,
    input logic                   sh_phase,
    input logic                   cnv_start,
    input logic [$clog2(NCH)-1:0] cnv_ch,
    input logic                   cnv_use_sh,
    input logic [NCH-1:0]         ch_en,
    input logic                   irq_en,
    input logic                   scan_irq
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start); // R3
    AST_USE_SH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_start && cnv_use_sh) |-> (int'(cnv_ch) < NSH)); // R4
    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |-> $past(irq_en)); // R6
    AST_IRQ_REOPENS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |-> (sh_phase && !cnv_start)); // R6
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |=> !scan_irq); // R6
    AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> (!cnv_start && !sh_phase)); // R8
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ch_en) == '0) |-> !cnv_start); // R10
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .NSH(NSH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .sh_phase   (sh_phase),
    .cnv_start  (cnv_start),
    .cnv_ch     (cnv_ch),
    .cnv_use_sh (cnv_use_sh),
    .ch_en      (ch_en),
    .irq_en     (irq_en),
    .scan_irq   (scan_irq)
);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
    localparam int LAT = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        sw_set = 0, sw_clr = 0, sync_trig = 0, async_trig = 0;
    logic [7:0]  ch_en = 0;
    logic [2:0]  sh_sel = 0;
    logic [7:0]  sh_cycles = 0;
    logic        irq_en = 0;
    logic        run, sh_phase, cnv_start, cnv_use_sh, scan_irq;
    logic [2:0]  sh_sample, cnv_ch;
    logic        cnv_done = 0;
    logic [11:0] cnv_data = 0;
    logic [95:0] res_all;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_scan_seq u0 (
        .clk(clk), .rst_n(rst_n), .sw_set(sw_set), .sw_clr(sw_clr),
        .sync_trig(sync_trig), .async_trig(async_trig), .ch_en(ch_en),
        .sh_sel(sh_sel), .sh_cycles(sh_cycles), .irq_en(irq_en), .run(run),
        .sh_phase(sh_phase), .sh_sample(sh_sample), .cnv_start(cnv_start),
        .cnv_ch(cnv_ch), .cnv_use_sh(cnv_use_sh), .cnv_done(cnv_done),
        .cnv_data(cnv_data), .scan_irq(scan_irq), .res_all(res_all)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_run, m_mode, m_timer, m_ch, m_irq;   // mode: 0 idle, 1 sampling, 2 start, 3 waiting
    int m_res [8];
    int pending [$];
    bit a1, a2, a3;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_mode = 0; m_timer = 0; m_ch = 0; m_irq = 0;
            foreach (m_res[i]) m_res[i] = 0;
            pending.delete();
            a1 = 0; a2 = 0; a3 = 0;
        end else begin
            bit e;
            int nrun, nirq, len;
            e = a2 && !a3;
            nrun = sw_clr ? 0 : ((sw_set || sync_trig || e) ? 1 : m_run);
            nirq = 0;
            len = (sh_cycles == 0) ? 1 : int'(sh_cycles);
            if (m_mode != 0 && m_run == 0) m_mode = 0;
            else if (m_mode == 0) begin
                if (m_run != 0 && ch_en != 0) begin m_mode = 1; m_timer = 0; end
            end else if (m_mode == 1) begin
                if (m_timer + 1 >= len) begin
                    pending.delete();
                    for (int i = 0; i < 8; i++) if (ch_en[i]) pending.push_back(i);
                    if (pending.size() == 0) m_mode = 0;
                    else begin m_ch = pending.pop_front(); m_mode = 2; end
                end else m_timer++;
            end else if (m_mode == 2) m_mode = 3;
            else if (cnv_done) begin
                m_res[m_ch] = cnv_data;
                if (pending.size() != 0) begin m_ch = pending.pop_front(); m_mode = 2; end
                else begin m_mode = 1; m_timer = 0; nirq = irq_en; end
            end
            m_run = nrun; m_irq = nirq;
            a3 = a2; a2 = a1; a1 = async_trig;
        end
    end

    // ---------------- per-cycle compare and converter model ----------------
    int irq_seen = 0, start_seen = 0, conv_pend = 0, seq = 0;
    bit r9_armed = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(run == (m_run != 0), "R1", "run", run, m_run);
            chk(sh_phase == (m_mode == 1), "R2", "sh_phase", sh_phase, m_mode == 1);
            chk(sh_sample == ((m_mode == 1) ? sh_sel : 3'd0), "R2", "sh_sample",
                sh_sample, (m_mode == 1) ? sh_sel : 0);
            chk(cnv_start == (m_mode == 2), "R3", "cnv_start", cnv_start, m_mode == 2);
            if (m_mode >= 2) begin
                chk(int'(cnv_ch) == m_ch, "R3", "cnv_ch", cnv_ch, m_ch);
                chk(cnv_use_sh == (m_ch < 3 && sh_sel[m_ch % 3] == 1'b1), "R4", "cnv_use_sh",
                    cnv_use_sh, (m_ch < 3 && sh_sel[m_ch % 3] == 1'b1));
            end
            chk(scan_irq == (m_irq != 0), "R6", "scan_irq", scan_irq, m_irq);
            for (int i = 0; i < 8; i++)
                chk(int'(res_all[i*12 +: 12]) == m_res[i], "R5", $sformatf("res[%0d]", i),
                    res_all[i*12 +: 12], m_res[i]);
            if (scan_irq) irq_seen++;
            if (cnv_start) start_seen++;
            if (!run) r9_armed = 1;
            else if (r9_armed && (sh_phase || cnv_start)) begin
                chk(sh_phase && !cnv_start, "R9", "restart begins with sampling", cnv_start, 0);
                r9_armed = 0;
            end
        end
        // converter: fixed latency, one done per start
        cnv_done = 0;
        if (conv_pend > 0) begin
            conv_pend--;
            if (conv_pend == 0) begin
                cnv_done = 1;
                seq = (seq + 37) % 256;
                cnv_data = {4'(cnv_ch + 3), 8'(seq)};
            end
        end
        if (rst_n && cnv_start) conv_pend = LAT;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1; @(negedge clk); s = 0;
    endtask

    initial begin
        int irq0, st0;
        logic [95:0] snap;
        cyc(4);
        rst_n = 1;
        cyc(1);
        chk(!run && !sh_phase && sh_sample == 0 && !cnv_start && !scan_irq, "R11",
            "outputs after reset", {run, sh_phase, cnv_start, scan_irq}, 0);
        chk(res_all == '0, "R11", "results after reset", res_all != 0, 0);

        // scan A: software start, mixed mask, hold on channels 0 and 2
        ch_en = 8'b1010_0101; sh_sel = 3'b101; sh_cycles = 8'd4; irq_en = 1;
        irq0 = irq_seen;
        pulse(sw_set);
        cyc(200);
        chk(irq_seen - irq0 >= 3, "R7", "scan ends while running", irq_seen - irq0, 3);

        // stop mid-conversion: pending done must be dropped
        do @(negedge clk); while (!cnv_start);
        cyc(2);
        pulse(sw_clr);
        cyc(1);
        snap = res_all; st0 = start_seen;
        cyc(20);
        chk(res_all == snap, "R8", "results unchanged after stop", res_all != snap, 0);
        chk(start_seen == st0, "R8", "no start after stop", start_seen - st0, 0);

        // scan B: sync trigger, single held channel, zero window length, no irq
        ch_en = 8'b0000_0010; sh_sel = 3'b010; sh_cycles = 0; irq_en = 0;
        irq0 = irq_seen;
        pulse(sync_trig);
        cyc(80);
        chk(irq_seen == irq0, "R6", "no irq when disabled", irq_seen - irq0, 0);
        pulse(sw_clr);
        cyc(20);

        // scan C: async trigger, only channels without hold stages
        ch_en = 8'hF0; sh_sel = 3'b111; sh_cycles = 8'd2; irq_en = 1;
        @(negedge clk); async_trig = 1;
        cyc(6); async_trig = 0;
        cyc(120);
        chk(run == 1'b1, "R1", "async trigger set run", run, 1);
        pulse(sw_clr);
        cyc(20);

        // set and clear in the same cycle: clear wins
        @(negedge clk); sw_set = 1; sw_clr = 1;
        @(negedge clk); sw_set = 0; sw_clr = 0;
        chk(run == 1'b0, "R1", "clear beats set", run, 0);
        cyc(10);

        // empty mask: run set, nothing happens
        ch_en = 0; irq0 = irq_seen; st0 = start_seen;
        pulse(sw_set);
        cyc(40);
        chk(start_seen == st0, "R10", "no start with empty mask", start_seen - st0, 0);
        chk(irq_seen == irq0, "R10", "no irq with empty mask", irq_seen - irq0, 0);
        pulse(sw_clr);
        cyc(5);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule